// File: doc/BRIEF.md
# Interleaved-Nibble Framebuffer Pixel Packer

This block takes pixels, each made of a 4-bit intensity and an (x, y) screen coordinate, and stores them in a byte-wide video memory. Each byte of that memory holds two horizontally adjacent pixels. The bits of the two pixels are interleaved within the byte.

For every pixel, the block does three things:
- It works out the byte address, using a layout of character rows, each eight scan lines tall.
- It spreads the four value bits onto that pixel's bit positions in the byte.
- It performs the memory access.

A right-hand (odd x) pixel is written directly and replaces the whole byte. A left-hand (even x) pixel is merged into the byte already stored there, by a read-modify-write.

The pixel source is expected to send pixels in descending x order. The odd pixel of each pair then arrives first and clears the byte, and its even partner is ORed into it. The source is held off with a ready signal while a memory access is in progress.

Top module: `nib_fb_packer`

## Requirements
- R1: The byte address is 0xC000 + (y>>3)*80 + (y&7)*0x800 + (x>>1), 16 bits wide. It is presented on `mem_addr` during the memory access for that pixel.
- R2: For even x, value bits 0, 1, 2 and 3 land on byte bits 7, 3, 5 and 1 respectively.
- R3: For odd x, value bits 0, 1, 2 and 3 land on byte bits 6, 2, 4 and 0 respectively.
- R4: An in-range pixel with odd x produces exactly one write, and no read. It replaces every bit of the addressed byte, so the stored byte has 0 in all positions the pixel does not use.
- R5: An in-range pixel with even x produces one read cycle, followed in the next cycle by one write to the same address. The written data is the read byte ORed with the spread pixel bits.
- R6: A pixel with x >= 160 or y >= 200 is accepted and dropped. It causes no read and no write, and `in_ready` stays high.
- R7: A pixel is taken when `in_valid` and `in_ready` are both high at a clock edge. After an in-range pixel is taken, `in_ready` is low in the next cycle. It stays low until the pixel's memory access is finished.
- R8: While reset is high and after reset, the block is idle: `in_ready` is high, and `mem_we` and `mem_re` are low.
- R9: `mem_we` and `mem_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_x | input | 8 | Horizontal coordinate |
| in_y | input | 8 | Vertical coordinate |
| in_val | input | 4 | Pixel intensity |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable (data returns next cycle) |
| mem_rdata | input | 8 | Memory read data |

## Verification
The bench covers several cases, and each catches a specific class of bug:
- The last scan line and last column (x=159, y=199) reach the highest address. A design that mis-weights the character-row term or the scan-line term writes somewhere else.
- Replacing a previously merged byte with a fresh odd pixel shows whether odd pixels truly overwrite. A design that ORs them in leaves stale bits behind.
- Merging an even pixel into a byte that the bench preloaded checks that the OR uses data read one cycle after the read strobe. Sampling at the wrong cycle writes back a wrong byte.
- Coordinates 160 and 200, just past the edge, would reveal an off-by-one range check as a stray write.

// File: rtl/nfp_pkg.sv
package nfp_pkg;

    localparam int ADDR_W = 16;
    localparam int VAL_W  = 4;
    localparam int BYTE_W = 8;

    // Byte-bit position of each value bit for a left (even x) pixel
    localparam int LEFT_POS [VAL_W] = '{7, 3, 5, 1};

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_MERGE = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] bits;
        logic              odd;
    } px_job_t;

endpackage

// File: rtl/nfp_addr_gen.sv
module nfp_addr_gen
    import nfp_pkg::*;
#(
    parameter int X_W          = 8,
    parameter int Y_W          = 8,
    parameter int BASE         = 'hC000,
    parameter int ROW_BYTES    = 80,
    parameter int ROW_LINES_L2 = 3,
    parameter int LINE_STEP_L2 = 11
) (
    input  logic [X_W-1:0]    x,
    input  logic [Y_W-1:0]    y,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] ROW_K  = ADDR_W'(ROW_BYTES);

    logic [ADDR_W-1:0] row_idx;
    logic [ADDR_W-1:0] line_idx;
    logic [ADDR_W-1:0] col_idx;
    logic [ADDR_W-1:0] row_off;

    assign row_idx  = ADDR_W'(y >> ROW_LINES_L2);
    assign line_idx = ADDR_W'(y[ROW_LINES_L2-1:0]);
    assign col_idx  = ADDR_W'(x >> 1);

    // Constant-coefficient product built from shifted copies only
    always_comb begin
        row_off = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            if (ROW_K[i]) row_off = row_off + (row_idx << i);
        end
    end

    assign addr = BASE_V + row_off + (line_idx << LINE_STEP_L2) + col_idx;

endmodule

// File: rtl/nfp_nib_map.sv
module nfp_nib_map
    import nfp_pkg::*;
(
    input  logic [VAL_W-1:0]  val,
    input  logic              odd,
    output logic [BYTE_W-1:0] bits
);
    logic [BYTE_W-1:0] left_bits;

    always_comb begin
        left_bits = '0;
        for (int i = 0; i < VAL_W; i++) begin
            left_bits[LEFT_POS[i]] = val[i];
        end
    end

    // Right pixel uses the neighbouring lower bit of each left position
    assign bits = odd ? (left_bits >> 1) : left_bits;

endmodule

// File: rtl/nfp_seq.sv
module nfp_seq
    import nfp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic job_odd,
    output logic ready,
    output logic load,
    output logic wr_direct,
    output logic rd_issue,
    output logic wr_merge
);
    seq_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (take) st_d = ST_ISSUE;
            ST_ISSUE: st_d = job_odd ? ST_IDLE : ST_MERGE;
            ST_MERGE: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign ready     = (st_q == ST_IDLE);
    assign load      = ready && take;
    assign wr_direct = (st_q == ST_ISSUE) && job_odd;
    assign rd_issue  = (st_q == ST_ISSUE) && !job_odd;
    assign wr_merge  = (st_q == ST_MERGE);

endmodule

// File: rtl/nib_fb_packer.sv
module nib_fb_packer
    import nfp_pkg::*;
#(
    parameter int X_W          = 8,
    parameter int Y_W          = 8,
    parameter int X_LIM        = 160,
    parameter int Y_LIM        = 200,
    parameter int BASE         = 'hC000,
    parameter int ROW_BYTES    = 80,
    parameter int ROW_LINES_L2 = 3,
    parameter int LINE_STEP_L2 = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [X_W-1:0]    in_x,
    input  logic [Y_W-1:0]    in_y,
    input  logic [VAL_W-1:0]  in_val,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [BYTE_W-1:0] mem_rdata
);
    localparam logic [X_W-1:0] X_TOP = X_W'(X_LIM - 1);
    localparam logic [Y_W-1:0] Y_TOP = Y_W'(Y_LIM - 1);

    logic              in_range;
    logic              take;
    logic              load;
    logic              wr_direct;
    logic              rd_issue;
    logic              wr_merge;
    logic [ADDR_W-1:0] calc_addr;
    logic [BYTE_W-1:0] calc_bits;
    px_job_t           job_d, job_q;

    assign in_range = (in_x <= X_TOP) && (in_y <= Y_TOP);
    assign take     = in_valid && in_range;

    nfp_addr_gen #(
        .X_W         (X_W),
        .Y_W         (Y_W),
        .BASE        (BASE),
        .ROW_BYTES   (ROW_BYTES),
        .ROW_LINES_L2(ROW_LINES_L2),
        .LINE_STEP_L2(LINE_STEP_L2)
    ) u_addr (
        .x   (in_x),
        .y   (in_y),
        .addr(calc_addr)
    );

    nfp_nib_map u_map (
        .val (in_val),
        .odd (in_x[0]),
        .bits(calc_bits)
    );

    nfp_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .job_odd  (job_q.odd),
        .ready    (in_ready),
        .load     (load),
        .wr_direct(wr_direct),
        .rd_issue (rd_issue),
        .wr_merge (wr_merge)
    );

    assign job_d = '{addr: calc_addr, bits: calc_bits, odd: in_x[0]};

    always_ff @(posedge clk) begin
        if (rst)       job_q <= '0;
        else if (load) job_q <= job_d;
    end

    assign mem_addr  = job_q.addr;
    assign mem_re    = rd_issue;
    assign mem_we    = wr_direct || wr_merge;
    assign mem_wdata = wr_merge ? (job_q.bits | mem_rdata) : job_q.bits;

endmodule

// File: rtl/nfp_checker.sv
module nfp_checker
    import nfp_pkg::*;
#(
    parameter int X_W   = 8,
    parameter int Y_W   = 8,
    parameter int X_LIM = 160,
    parameter int Y_LIM = 200
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [X_W-1:0]    in_x,
    input logic [Y_W-1:0]    in_y,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr
);
    logic fits;
    assign fits = (32'(in_x) < X_LIM) && (32'(in_y) < Y_LIM);

    // R9
    exclusive_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R5
    merge_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> (mem_we && !mem_re && mem_addr == $past(mem_addr)));

    // R4
    odd_direct_write_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && fits && in_x[0]) |=> (mem_we && !mem_re));

    // R6
    drop_no_access_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !fits) |=> (!mem_we && !mem_re && in_ready));

    // R7
    stall_after_take_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && fits) |=> !in_ready);

    // R8
    idle_after_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> (in_ready && !mem_we && !mem_re));

endmodule

bind nib_fb_packer nfp_checker #(
    .X_W  (X_W),
    .Y_W  (Y_W),
    .X_LIM(X_LIM),
    .Y_LIM(Y_LIM)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .in_x    (in_x),
    .in_y    (in_y),
    .mem_we  (mem_we),
    .mem_re  (mem_re),
    .mem_addr(mem_addr)
);

// File: tb/tb_nib_fb_packer.sv
`timescale 1ns/1ps
module tb_nib_fb_packer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_x = '0;
    logic [7:0]  in_y = '0;
    logic [3:0]  in_val = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        mem_re;
    logic [7:0]  mem_rdata = '0;

    int checks = 0;
    int failures = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int both_cnt = 0;
    logic [15:0] last_wa = '0;
    logic [7:0] vmem [int];

    always #2.5 clk = ~clk;

    nib_fb_packer dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_x     (in_x),
        .in_y     (in_y),
        .in_val   (in_val),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_we   (mem_we),
        .mem_re   (mem_re),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] peek(input int a);
        return vmem.exists(a) ? vmem[a] : 8'h00;
    endfunction

    // Memory model with one-cycle read latency
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= peek(int'(mem_addr));
        if (mem_we) vmem[int'(mem_addr)] = mem_wdata;
        if (!rst) begin
            if (mem_we) begin wr_cnt++; last_wa = mem_addr; end
            if (mem_re) rd_cnt++;
            if (mem_we && mem_re) both_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    logic ready_after;

    task automatic send(input int x, input int y, input int v);
        @(negedge clk);
        in_x = 8'(x); in_y = 8'(y); in_val = 4'(v); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        ready_after = in_ready;
        repeat (4) @(negedge clk);
    endtask

    // {x, y, value, expected address, expected byte after the pixel}
    localparam int NV = 12;
    localparam logic [47:0] VEC [NV] = '{
        {8'd159, 8'd199, 8'h0F, 16'hFFCF, 8'h55},
        {8'd158, 8'd199, 8'h0F, 16'hFFCF, 8'hFF},
        {8'd1,   8'd0,   8'h01, 16'hC000, 8'h40},
        {8'd0,   8'd0,   8'h02, 16'hC000, 8'h48},
        {8'd3,   8'd9,   8'h04, 16'hC851, 8'h10},
        {8'd2,   8'd9,   8'h08, 16'hC851, 8'h12},
        {8'd77,  8'd100, 8'h0A, 16'hE3E6, 8'h05},
        {8'd76,  8'd100, 8'h05, 16'hE3E6, 8'hA5},
        {8'd1,   8'd0,   8'h08, 16'hC000, 8'h01},
        {8'd0,   8'd0,   8'h00, 16'hC000, 8'h01},
        {8'd41,  8'd63,  8'h03, 16'hFA44, 8'h44},
        {8'd40,  8'd63,  8'h0C, 16'hFA44, 8'h66}
    };

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: idle while reset is held
        chk(in_ready === 1'b1, "R8 ready in reset", int'(in_ready), 1);
        chk(mem_we === 1'b0 && mem_re === 1'b0, "R8 strobes in reset", int'({mem_we, mem_re}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready === 1'b1, "R8 ready after reset", int'(in_ready), 1);

        for (int i = 0; i < NV; i++) begin
            int vx, vy, vv, ea, eb, w0, r0;
            vx = int'(VEC[i][47:40]); vy = int'(VEC[i][39:32]);
            vv = int'(VEC[i][31:24]); ea = int'(VEC[i][23:8]);
            eb = int'(VEC[i][7:0]);
            w0 = wr_cnt; r0 = rd_cnt;
            send(vx, vy, vv);
            chk(int'(last_wa) == ea, "R1 address", int'(last_wa), ea);
            if (vx % 2 == 1) begin
                chk(peek(ea) == 8'(eb), "R3 odd bit map", int'(peek(ea)), eb);
                chk(wr_cnt - w0 == 1 && rd_cnt == r0, "R4 single write no read",
                    (wr_cnt - w0) * 16 + (rd_cnt - r0), 16);
            end else begin
                chk(peek(ea) == 8'(eb), "R2 even bit map merged", int'(peek(ea)), eb);
                chk(wr_cnt - w0 == 1 && rd_cnt - r0 == 1, "R5 read then write",
                    (wr_cnt - w0) * 16 + (rd_cnt - r0), 17);
            end
        end

        // R5: merge into a byte that holds unrelated data; R7 stall
        vmem[int'(16'hC0AA)] = 8'h11;
        send(20, 16, 15);
        chk(ready_after === 1'b0, "R7 ready low after take", int'(ready_after), 0);
        chk(peek(int'(16'hC0AA)) == 8'hBB, "R5 OR with stored byte", int'(peek(int'(16'hC0AA))), 'hBB);
        chk(in_ready === 1'b1, "R7 ready back when done", int'(in_ready), 1);

        // R6: coordinates just past the edge are dropped
        begin
            int w0, r0;
            w0 = wr_cnt; r0 = rd_cnt;
            send(160, 0, 15);
            chk(ready_after === 1'b1, "R6 ready stays high x", int'(ready_after), 1);
            send(0, 200, 15);
            chk(ready_after === 1'b1, "R6 ready stays high y", int'(ready_after), 1);
            chk(wr_cnt == w0 && rd_cnt == r0, "R6 no memory access",
                (wr_cnt - w0) * 16 + (rd_cnt - r0), 0);
            chk(peek(int'(16'hC000)) == 8'h01, "R6 memory untouched", int'(peek(int'(16'hC000))), 1);
        end

        // R9: never read and write together
        chk(both_cnt == 0, "R9 exclusive strobes", both_cnt, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule